// File: doc/BRIEF.md
# Fence-Driven Data-Cache Flush Sequencer

This block connects the fence handling of a processor core to the request port of a data cache. A memory fence or an instruction fence can start a flush of the whole data cache. The block stalls the core and sends one flush command on the cache's shared request port. It then waits for the cache to report that the flush is done, and only then releases the stall. An instruction fence also sends a one-cycle flush strobe to the instruction cache. This keeps instruction fetch coherent after software has written code through a write-back data cache.

The request port is shared with the store path and the atomic path. An atomic request always wins, a store comes second, and the flush command goes out only when neither of the other two is present. The flush command uses the fixed transaction id 0. The cache marks the end of the flush by returning a response with id 0. Two static parameters control the behaviour. The first decides whether a fence causes a flush at all. The second decides whether the flush also invalidates the cache lines.

Top module: `fence_flush_seq`

## Requirements
- R1: After an asynchronous active-low reset, the block idles with `halt`, `reqValid`, `flushAck` and `icacheFlush` all low.
- R2: With `FlushOnFence`=1, a cycle with `fenceEvt` or `fenceIEvt` high makes `halt` and the flush request (`reqValid` high) visible in the next cycle.
- R3: A cycle with `fenceIEvt` high makes `icacheFlush` high for exactly the next cycle, for every parameter setting.
- R4: The flush command carries `reqTid`=0, `reqNeedRsp`=1 and `reqPhysIdx`=0, and has zero `reqAddr`, `reqData`, `reqBe` and `reqSize`.
- R5: The flush opcode is 4'h9 (flush and invalidate all lines) when `InvalOnFlush`=1, and 4'h8 (flush all lines) otherwise.
- R6: The flush request stays valid with unchanged fields until a cycle with `reqReady` high. After that cycle it is withdrawn while the block waits for the response.
- R7: While the block waits, a response with a non-zero `rspTid` is ignored: no `flushAck` is given and `halt` stays high.
- R8: While the block waits, a response with `rspTid`=0 produces a single-cycle `flushAck` in that same cycle, and `halt` is low from the next cycle on.
- R9: On the shared port, the atomic request (opcode `amoOp`, tid all ones, response requested, physically indexed) has priority over the store (opcode 4'h1, tid 0, no response, physically indexed). The store has priority over the flush. A flush held back by either one does not advance the handshake.
- R10: With `FlushOnFence`=0, fences never raise the flush request and never assert `halt`.
- R11: A response with `rspTid`=0 that arrives while no flush is outstanding does not produce `flushAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fenceEvt | input | 1 | Memory fence executed this cycle |
| fenceIEvt | input | 1 | Instruction fence executed this cycle |
| amoValid | input | 1 | Atomic request present |
| amoOp | input | 4 | Atomic opcode |
| amoAddr | input | AddrW | Atomic address |
| amoData | input | DataW | Atomic operand |
| amoBe | input | DataW/8 | Atomic byte enables |
| amoSize | input | SizeW | Atomic access size |
| storeValid | input | 1 | Store request present |
| storeAddr | input | AddrW | Store address |
| storeData | input | DataW | Store data |
| storeBe | input | DataW/8 | Store byte enables |
| storeSize | input | SizeW | Store access size |
| reqReady | input | 1 | Cache accepts the request this cycle |
| rspValid | input | 1 | Cache response present |
| rspTid | input | TidW | Transaction id of the response |
| reqValid | output | 1 | Request to the cache valid |
| reqOp | output | 4 | Request opcode |
| reqTid | output | TidW | Request transaction id |
| reqNeedRsp | output | 1 | Request expects a response |
| reqPhysIdx | output | 1 | Request is physically indexed |
| reqAddr | output | AddrW | Request address |
| reqData | output | DataW | Request write data |
| reqBe | output | DataW/8 | Request byte enables |
| reqSize | output | SizeW | Request size |
| icacheFlush | output | 1 | One-cycle instruction-cache flush strobe |
| halt | output | 1 | Stall the core while a fence flush runs |
| flushAck | output | 1 | One-cycle flush completion pulse |

## Verification
Some properties are checked by assertions on every cycle:
- at most one source is forwarded at a time;
- a flush request that has not been accepted is still present in the next cycle;
- `flushAck` never lasts more than one cycle, and `halt` is low after it;
- `halt` stays high while a fence is active and no acknowledge has come;
- an instruction fence is always followed by the instruction-cache strobe.

Other behaviour can only be shown by the bench scenarios:
- the exact field values of each accepted command, which are compared against a queue of expected commands;
- the choice of opcode made by each parameter setting;
- that wrong-id and idle responses are ignored;
- that a flush held back behind atomic and store traffic is still sent after them.

// File: rtl/ffs_pkg.sv
package ffs_pkg;
  localparam int OpW = 4;

  localparam logic [OpW-1:0] OP_STORE     = 4'h1;
  localparam logic [OpW-1:0] OP_FLUSH_ALL = 4'h8;
  localparam logic [OpW-1:0] OP_FLUSH_INV = 4'h9;

  typedef enum logic {
    HS_IDLE,
    HS_WAIT
  } hsState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic flushWant;
  } ctrlStrobe_t;
endpackage

// File: rtl/ffs_ctrl.sv
module ffs_ctrl #(
  parameter bit FlushOnFence = 1'b1,
  parameter int TidW         = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                fenceEvt,
  input  logic                fenceIEvt,
  input  logic                reqReady,
  input  logic                flushFwd,
  input  logic                rspValid,
  input  logic [TidW-1:0]     rspTid,
  output ffs_pkg::ctrlStrobe_t strobe,
  output logic                halt,
  output logic                flushAck,
  output logic                icacheFlush
);
  import ffs_pkg::*;

  hsState_e stateQ, stateD;
  logic     activeQ, activeD;
  logic     icQ;
  logic     fenceHit;
  logic     ack;

  assign fenceHit = FlushOnFence && (fenceEvt || fenceIEvt);

  always_comb begin
    stateD = stateQ;
    ack    = 1'b0;
    case (stateQ)
      HS_IDLE: if (activeQ && flushFwd && reqReady) stateD = HS_WAIT;
      HS_WAIT: begin
        if (rspValid && (rspTid == '0)) begin
          ack    = 1'b1;
          stateD = HS_IDLE;
        end
      end
      default: stateD = HS_IDLE;
    endcase
  end

  assign activeD = fenceHit || (activeQ && !ack);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= HS_IDLE;
      activeQ <= 1'b0;
      icQ     <= 1'b0;
    end else begin
      stateQ  <= stateD;
      activeQ <= activeD;
      icQ     <= fenceIEvt;
    end
  end

  assign strobe.flushWant = (stateQ == HS_IDLE) && activeQ;
  assign halt             = FlushOnFence && activeQ;
  assign flushAck         = ack;
  assign icacheFlush      = icQ;

  assert_ack_single_R8 : assert property (@(posedge clk) disable iff (!rstN)
    flushAck |=> !flushAck);
  assert_halt_drop_R8 : assert property (@(posedge clk) disable iff (!rstN)
    (flushAck && !fenceHit) |=> !halt);
  assert_halt_hold_R7 : assert property (@(posedge clk) disable iff (!rstN)
    (halt && !flushAck) |=> halt);
  assert_req_hold_R6 : assert property (@(posedge clk) disable iff (!rstN)
    (strobe.flushWant && !(flushFwd && reqReady)) |=> strobe.flushWant);
  assert_icache_strobe_R3 : assert property (@(posedge clk) disable iff (!rstN)
    fenceIEvt |=> icacheFlush);
endmodule

// File: rtl/ffs_datapath.sv
module ffs_datapath #(
  parameter bit InvalOnFlush = 1'b0,
  parameter int AddrW        = 32,
  parameter int DataW        = 64,
  parameter int TidW         = 3,
  parameter int SizeW        = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ffs_pkg::ctrlStrobe_t     strobe,
  input  logic                     amoValid,
  input  logic [ffs_pkg::OpW-1:0]  amoOp,
  input  logic [AddrW-1:0]         amoAddr,
  input  logic [DataW-1:0]         amoData,
  input  logic [DataW/8-1:0]       amoBe,
  input  logic [SizeW-1:0]         amoSize,
  input  logic                     storeValid,
  input  logic [AddrW-1:0]         storeAddr,
  input  logic [DataW-1:0]         storeData,
  input  logic [DataW/8-1:0]       storeBe,
  input  logic [SizeW-1:0]         storeSize,
  output logic                     flushFwd,
  output logic                     reqValid,
  output logic [ffs_pkg::OpW-1:0]  reqOp,
  output logic [TidW-1:0]          reqTid,
  output logic                     reqNeedRsp,
  output logic                     reqPhysIdx,
  output logic [AddrW-1:0]         reqAddr,
  output logic [DataW-1:0]         reqData,
  output logic [DataW/8-1:0]       reqBe,
  output logic [SizeW-1:0]         reqSize
);
  import ffs_pkg::*;

  localparam logic [OpW-1:0] FlushOp = InvalOnFlush ? OP_FLUSH_INV : OP_FLUSH_ALL;

  logic amoFwd, storeFwd;

  assign amoFwd   = amoValid;
  assign storeFwd = storeValid && !amoValid;
  assign flushFwd = strobe.flushWant && !amoValid && !storeValid;
  assign reqValid = amoValid || storeValid || strobe.flushWant;

  always_comb begin
    reqOp      = FlushOp;
    reqTid     = '0;
    reqNeedRsp = 1'b1;
    reqPhysIdx = 1'b0;
    reqAddr    = '0;
    reqData    = '0;
    reqBe      = '0;
    reqSize    = '0;
    if (amoFwd) begin
      reqOp      = amoOp;
      reqTid     = '1;
      reqNeedRsp = 1'b1;
      reqPhysIdx = 1'b1;
      reqAddr    = amoAddr;
      reqData    = amoData;
      reqBe      = amoBe;
      reqSize    = amoSize;
    end else if (storeFwd) begin
      reqOp      = OP_STORE;
      reqTid     = '0;
      reqNeedRsp = 1'b0;
      reqPhysIdx = 1'b1;
      reqAddr    = storeAddr;
      reqData    = storeData;
      reqBe      = storeBe;
      reqSize    = storeSize;
    end
  end

  assert_one_source_R9 : assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({amoFwd, storeFwd, flushFwd}));
  assert_flush_fields_R4 : assert property (@(posedge clk) disable iff (!rstN)
    flushFwd |-> (reqTid == '0 && reqNeedRsp && !reqPhysIdx && reqAddr == '0 && reqBe == '0));
  assert_flush_stable_R6 : assert property (@(posedge clk) disable iff (!rstN)
    (flushFwd && $past(flushFwd)) |-> $stable(reqOp));
endmodule

// File: rtl/fence_flush_seq.sv
module fence_flush_seq #(
  parameter bit FlushOnFence = 1'b1,
  parameter bit InvalOnFlush = 1'b0,
  parameter int AddrW        = 32,
  parameter int DataW        = 64,
  parameter int TidW         = 3,
  parameter int SizeW        = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    fenceEvt,
  input  logic                    fenceIEvt,
  input  logic                    amoValid,
  input  logic [3:0]              amoOp,
  input  logic [AddrW-1:0]        amoAddr,
  input  logic [DataW-1:0]        amoData,
  input  logic [DataW/8-1:0]      amoBe,
  input  logic [SizeW-1:0]        amoSize,
  input  logic                    storeValid,
  input  logic [AddrW-1:0]        storeAddr,
  input  logic [DataW-1:0]        storeData,
  input  logic [DataW/8-1:0]      storeBe,
  input  logic [SizeW-1:0]        storeSize,
  input  logic                    reqReady,
  input  logic                    rspValid,
  input  logic [TidW-1:0]         rspTid,
  output logic                    reqValid,
  output logic [3:0]              reqOp,
  output logic [TidW-1:0]         reqTid,
  output logic                    reqNeedRsp,
  output logic                    reqPhysIdx,
  output logic [AddrW-1:0]        reqAddr,
  output logic [DataW-1:0]        reqData,
  output logic [DataW/8-1:0]      reqBe,
  output logic [SizeW-1:0]        reqSize,
  output logic                    icacheFlush,
  output logic                    halt,
  output logic                    flushAck
);
  ffs_pkg::ctrlStrobe_t strobe;
  logic                 flushFwd;

  ffs_ctrl #(
    .FlushOnFence(FlushOnFence),
    .TidW        (TidW)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .fenceEvt   (fenceEvt),
    .fenceIEvt  (fenceIEvt),
    .reqReady   (reqReady),
    .flushFwd   (flushFwd),
    .rspValid   (rspValid),
    .rspTid     (rspTid),
    .strobe     (strobe),
    .halt       (halt),
    .flushAck   (flushAck),
    .icacheFlush(icacheFlush)
  );

  ffs_datapath #(
    .InvalOnFlush(InvalOnFlush),
    .AddrW       (AddrW),
    .DataW       (DataW),
    .TidW        (TidW),
    .SizeW       (SizeW)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .amoValid  (amoValid),
    .amoOp     (amoOp),
    .amoAddr   (amoAddr),
    .amoData   (amoData),
    .amoBe     (amoBe),
    .amoSize   (amoSize),
    .storeValid(storeValid),
    .storeAddr (storeAddr),
    .storeData (storeData),
    .storeBe   (storeBe),
    .storeSize (storeSize),
    .flushFwd  (flushFwd),
    .reqValid  (reqValid),
    .reqOp     (reqOp),
    .reqTid    (reqTid),
    .reqNeedRsp(reqNeedRsp),
    .reqPhysIdx(reqPhysIdx),
    .reqAddr   (reqAddr),
    .reqData   (reqData),
    .reqBe     (reqBe),
    .reqSize   (reqSize)
  );
endmodule

// File: tb/fence_flush_seq_tb.sv
`timescale 1ns/1ps
module fence_flush_seq_tb;
  typedef struct packed {
    logic [3:0]  op;
    logic [2:0]  tid;
    logic        needRsp;
    logic        physIdx;
    logic [31:0] addr;
    logic [63:0] data;
    logic [7:0]  be;
    logic [2:0]  size;
  } reqRec_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fenceEvt = 0, fenceIEvt = 0;
  logic amoValid = 0, storeValid = 0;
  logic [3:0]  amoOp = 4'h4;
  logic [31:0] amoAddr = 32'h1000_0040, storeAddr = 32'h2000_0008;
  logic [63:0] amoData = 64'hAAAA_5555_0000_1111, storeData = 64'h1234_5678_9ABC_DEF0;
  logic [7:0]  amoBe = 8'h0F, storeBe = 8'hFF;
  logic [2:0]  amoSize = 3'd2, storeSize = 3'd3;
  logic reqReady = 0, rspValid = 0;
  logic [2:0] rspTid = 0;

  logic        reqValid[3];
  logic [3:0]  reqOp[3];
  logic [2:0]  reqTid[3];
  logic        reqNeedRsp[3];
  logic        reqPhysIdx[3];
  logic [31:0] reqAddr[3];
  logic [63:0] reqData[3];
  logic [7:0]  reqBe[3];
  logic [2:0]  reqSize[3];
  logic        icacheFlush[3];
  logic        halt[3];
  logic        flushAck[3];

  int checks = 0;
  int errors = 0;
  bit done = 0;
  reqRec_t expQ0[$], expQ1[$], expQ2[$];

  always #4 clk = ~clk;

  fence_flush_seq #(.FlushOnFence(1'b1), .InvalOnFlush(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .fenceEvt(fenceEvt), .fenceIEvt(fenceIEvt),
    .amoValid(amoValid), .amoOp(amoOp), .amoAddr(amoAddr), .amoData(amoData),
    .amoBe(amoBe), .amoSize(amoSize), .storeValid(storeValid), .storeAddr(storeAddr),
    .storeData(storeData), .storeBe(storeBe), .storeSize(storeSize),
    .reqReady(reqReady), .rspValid(rspValid), .rspTid(rspTid),
    .reqValid(reqValid[0]), .reqOp(reqOp[0]), .reqTid(reqTid[0]),
    .reqNeedRsp(reqNeedRsp[0]), .reqPhysIdx(reqPhysIdx[0]), .reqAddr(reqAddr[0]),
    .reqData(reqData[0]), .reqBe(reqBe[0]), .reqSize(reqSize[0]),
    .icacheFlush(icacheFlush[0]), .halt(halt[0]), .flushAck(flushAck[0]));

  fence_flush_seq #(.FlushOnFence(1'b1), .InvalOnFlush(1'b1)) u_dutInv (
    .clk(clk), .rstN(rstN), .fenceEvt(fenceEvt), .fenceIEvt(fenceIEvt),
    .amoValid(amoValid), .amoOp(amoOp), .amoAddr(amoAddr), .amoData(amoData),
    .amoBe(amoBe), .amoSize(amoSize), .storeValid(storeValid), .storeAddr(storeAddr),
    .storeData(storeData), .storeBe(storeBe), .storeSize(storeSize),
    .reqReady(reqReady), .rspValid(rspValid), .rspTid(rspTid),
    .reqValid(reqValid[1]), .reqOp(reqOp[1]), .reqTid(reqTid[1]),
    .reqNeedRsp(reqNeedRsp[1]), .reqPhysIdx(reqPhysIdx[1]), .reqAddr(reqAddr[1]),
    .reqData(reqData[1]), .reqBe(reqBe[1]), .reqSize(reqSize[1]),
    .icacheFlush(icacheFlush[1]), .halt(halt[1]), .flushAck(flushAck[1]));

  fence_flush_seq #(.FlushOnFence(1'b0), .InvalOnFlush(1'b0)) u_dutOff (
    .clk(clk), .rstN(rstN), .fenceEvt(fenceEvt), .fenceIEvt(fenceIEvt),
    .amoValid(amoValid), .amoOp(amoOp), .amoAddr(amoAddr), .amoData(amoData),
    .amoBe(amoBe), .amoSize(amoSize), .storeValid(storeValid), .storeAddr(storeAddr),
    .storeData(storeData), .storeBe(storeBe), .storeSize(storeSize),
    .reqReady(reqReady), .rspValid(rspValid), .rspTid(rspTid),
    .reqValid(reqValid[2]), .reqOp(reqOp[2]), .reqTid(reqTid[2]),
    .reqNeedRsp(reqNeedRsp[2]), .reqPhysIdx(reqPhysIdx[2]), .reqAddr(reqAddr[2]),
    .reqData(reqData[2]), .reqBe(reqBe[2]), .reqSize(reqSize[2]),
    .icacheFlush(icacheFlush[2]), .halt(halt[2]), .flushAck(flushAck[2]));

  task automatic check(string tag, bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic sample();
    @(negedge clk);
  endtask

  function automatic reqRec_t flushRec(bit inv);
    reqRec_t r = '0;
    r.op = inv ? 4'h9 : 4'h8;   // R5 opcodes
    r.needRsp = 1'b1;           // R4 fields
    return r;
  endfunction

  function automatic reqRec_t storeRec();
    reqRec_t r;
    r = '{op: 4'h1, tid: 3'd0, needRsp: 1'b0, physIdx: 1'b1,
          addr: storeAddr, data: storeData, be: storeBe, size: storeSize};
    return r;
  endfunction

  function automatic reqRec_t amoRec();
    reqRec_t r;
    r = '{op: amoOp, tid: 3'h7, needRsp: 1'b1, physIdx: 1'b1,
          addr: amoAddr, data: amoData, be: amoBe, size: amoSize};
    return r;
  endfunction

  function automatic reqRec_t seen(int i);
    reqRec_t r;
    r = '{op: reqOp[i], tid: reqTid[i], needRsp: reqNeedRsp[i], physIdx: reqPhysIdx[i],
          addr: reqAddr[i], data: reqData[i], be: reqBe[i], size: reqSize[i]};
    return r;
  endfunction

  task automatic popCompare(int i, reqRec_t got);
    reqRec_t exp;
    bit empty;
    case (i)
      0: empty = (expQ0.size() == 0);
      1: empty = (expQ1.size() == 0);
      default: empty = (expQ2.size() == 0);
    endcase
    if (empty) begin
      check("R9", 1'b0, $sformatf("unexpected accept on dut%0d op", i), got.op, 0);
      return;
    end
    case (i)
      0: exp = expQ0.pop_front();
      1: exp = expQ1.pop_front();
      default: exp = expQ2.pop_front();
    endcase
    check("R4/R9", got == exp, $sformatf("accepted command dut%0d (op.tid)", i),
          {got.op, 1'b0, got.tid}, {exp.op, 1'b0, exp.tid});
    check("R4/R9", got.data == exp.data && got.addr == exp.addr,
          $sformatf("accepted payload dut%0d", i), got.addr, exp.addr);
  endtask

  // monitor: pop and compare every accepted request
  always @(negedge clk) begin
    if (rstN && !done) begin
      for (int i = 0; i < 3; i++) begin
        if (reqValid[i] && reqReady) popCompare(i, seen(i));
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      check("R1", 1'b0, "watchdog expired", 0, 1);
      summary();
    end
  end

  initial begin
    repeat (3) tick();
    sample();
    for (int i = 0; i < 3; i++) begin
      check("R1", !halt[i] && !reqValid[i] && !flushAck[i] && !icacheFlush[i],
            $sformatf("reset outputs dut%0d", i),
            {halt[i], reqValid[i], flushAck[i], icacheFlush[i]}, 0);
    end
    tick(); rstN = 1'b1;
    tick();

    // memory fence, ready delayed
    fenceEvt = 1; tick(); fenceEvt = 0;
    sample();
    check("R2", halt[0] && halt[1], "halt after fence", {halt[0], halt[1]}, 2'b11);
    check("R2", reqValid[0] && reqValid[1], "flush request after fence", reqValid[0], 1);
    check("R10", !halt[2] && !reqValid[2], "disabled instance quiet", {halt[2], reqValid[2]}, 0);
    check("R5", reqOp[0] == 4'h8, "flush opcode", reqOp[0], 4'h8);
    check("R5", reqOp[1] == 4'h9, "flush-inval opcode", reqOp[1], 4'h9);
    for (int k = 0; k < 3; k++) begin
      tick(); sample();
      check("R6", reqValid[0] && reqOp[0] == 4'h8, "request held without ready", reqValid[0], 1);
    end
    expQ0.push_back(flushRec(0)); expQ1.push_back(flushRec(1));
    tick(); reqReady = 1; sample();
    tick(); reqReady = 0; sample();
    check("R6", !reqValid[0], "request withdrawn after accept", reqValid[0], 0);
    check("R7", halt[0], "halt while waiting", halt[0], 1);
    tick(); rspValid = 1; rspTid = 3'd3; sample();
    check("R7", !flushAck[0] && !flushAck[1], "non-zero id ignored", flushAck[0], 0);
    tick(); rspTid = 3'd0; sample();
    check("R7", halt[0], "halt kept after wrong id", halt[0], 1);
    check("R8", flushAck[0] && flushAck[1], "ack on zero id", {flushAck[0], flushAck[1]}, 2'b11);
    check("R11", !flushAck[2], "no ack on idle instance", flushAck[2], 0);
    tick(); rspValid = 0; sample();
    check("R8", !flushAck[0], "ack single cycle", flushAck[0], 0);
    check("R8", !halt[0] && !halt[1], "halt released after ack", halt[0], 0);

    // instruction fence, ready already high
    expQ0.push_back(flushRec(0)); expQ1.push_back(flushRec(1));
    tick(); reqReady = 1; fenceIEvt = 1;
    tick(); fenceIEvt = 0; sample();
    for (int i = 0; i < 3; i++)
      check("R3", icacheFlush[i], $sformatf("icache strobe dut%0d", i), icacheFlush[i], 1);
    check("R2", reqValid[0] && halt[0], "flush after instruction fence", reqValid[0], 1);
    tick(); reqReady = 0; sample();
    check("R3", !icacheFlush[0] && !icacheFlush[2], "icache strobe one cycle", icacheFlush[0], 0);
    check("R10", !halt[2], "no halt on disabled instance", halt[2], 0);
    tick(); rspValid = 1; rspTid = 0; sample();
    check("R8", flushAck[0], "ack after instruction fence flush", flushAck[0], 1);
    tick(); rspValid = 0; sample();
    check("R8", !halt[0], "halt released", halt[0], 0);

    // stray zero-id response while idle
    tick(); rspValid = 1; rspTid = 0; sample();
    check("R11", !flushAck[0] && !flushAck[1] && !flushAck[2], "idle zero-id ignored", flushAck[0], 0);
    tick(); rspValid = 0;

    // priority on the shared port
    fenceEvt = 1; tick(); fenceEvt = 0; amoValid = 1; storeValid = 1; sample();
    check("R9", reqOp[0] == amoOp && reqAddr[0] == amoAddr, "atomic wins", reqOp[0], amoOp);
    check("R9", reqValid[2] && reqOp[2] == amoOp, "atomic on disabled instance", reqOp[2], amoOp);
    tick(); amoValid = 0; sample();
    check("R9", reqOp[0] == 4'h1 && reqAddr[0] == storeAddr, "store over flush", reqOp[0], 4'h1);
    tick(); storeValid = 0; sample();
    check("R9", reqOp[0] == 4'h8, "flush when alone", reqOp[0], 4'h8);
    expQ0.push_back(amoRec()); expQ1.push_back(amoRec()); expQ2.push_back(amoRec());
    tick(); amoValid = 1; storeValid = 1; reqReady = 1; sample();
    expQ0.push_back(storeRec()); expQ1.push_back(storeRec()); expQ2.push_back(storeRec());
    tick(); amoValid = 0; sample();
    expQ0.push_back(flushRec(0)); expQ1.push_back(flushRec(1));
    tick(); storeValid = 0; sample();
    tick(); reqReady = 0; sample();
    check("R9", halt[0] && !reqValid[0], "held-back flush issued then waiting", reqValid[0], 0);
    tick(); rspValid = 1; rspTid = 0; sample();
    check("R8", flushAck[0] && flushAck[1], "ack after contended flush", flushAck[0], 1);
    tick(); rspValid = 0; sample();
    check("R8", !halt[0], "halt released after contended flush", halt[0], 0);

    tick(); tick();
    check("R9", expQ0.size() == 0 && expQ1.size() == 0 && expQ2.size() == 0,
          "all expected commands seen", expQ0.size() + expQ1.size() + expQ2.size(), 0);
    done = 1;
    summary();
  end
endmodule